// File: doc/BRIEF.md
# Hybrid Radix-2 Signed-Digit Adder

This block adds a W-digit radix-2 signed-digit operand to a W-bit unsigned binary operand and returns a signed-digit sum of W+1 digits. No carry ripples across the word. Every digit position first forms a local sum of its two input digits and splits it into a transfer bit, which moves one position up, and an interim minus bit, which stays in place. Each output digit is then assembled from the transfer of the position below and its own interim bit. The logic depth is the same for every width.

Each signed digit travels on two wires, a plus bit and a minus bit, and its value is plus minus minus. The top transfer is kept as an extra most significant digit, so the sum is exact and never overflows. A parameter selects between a purely combinational path and a single output register. The register resets synchronously to the all-zero encoding.

Top module: `sd_hybrid_adder`

## Requirements
- R1: An operand or result digit at position i is the pair (plus bit, minus bit) taken from bit i of the plus and minus vectors. Its value is plus minus minus, so 00 and 11 are zero, 10 is +1 and 01 is -1. A vector's value is the sum of digit value times 2^i.
- R2: The value of the W+1 digit result equals value(X) + Y exactly, for every operand pair.
- R3: For each position i, let p = x_i + y_i. The interim minus bit is set exactly when p is -1 or +1, and the transfer is set exactly when p is at least 1, so p = 2*transfer - interim.
- R4: For 1 <= i <= W-1, result digit i has its plus bit equal to the transfer of position i-1 and its minus bit equal to the interim bit of position i.
- R5: The plus bit of result digit 0 is always 0, because no transfer enters the lowest position.
- R6: Result digit W carries the transfer of position W-1 as its plus bit, and its minus bit is always 0.
- R7: With REG_OUT=1 the result for inputs applied before a rising clock edge appears right after that edge. With REG_OUT=0 the result follows the inputs in the same cycle.
- R8: With REG_OUT=1, a clock edge with rst_n low clears both result vectors to zero, whatever the inputs are.
- R9: Writing an input digit as 11 instead of 00 gives the same result bits.
- R10: Changing the inputs at position j alters only result digits j and j+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| x_pos | input | W | Plus bits of the signed-digit operand |
| x_neg | input | W | Minus bits of the signed-digit operand |
| y | input | W | Unsigned binary operand |
| s_pos | output | W+1 | Plus bits of the signed-digit sum |
| s_neg | output | W+1 | Minus bits of the signed-digit sum |

## Verification
The checker tests the following on every cycle:
- the per-position relation between local sum, transfer and interim bit;
- the routing of transfers into the next digit;
- the two constant bits at the ends of the result;
- that the sum equals the operand values seen one cycle earlier;
- that a reset edge clears the register.

Only the bench's scenarios can show three further properties. The first is that both encodings of zero give identical results, which the bench covers by sweeping every digit code against every Y. The second is that a change at one position reaches no further than the next digit. The third is that the result matches integer arithmetic for all 4096 operand pairs at W = 4.

// File: rtl/sd_pkg.sv
package sd_pkg;

  // Transfer out of one position: set when x+ - x- + y >= 1.
  function automatic logic ppm_xfer(input logic xp, input logic xn, input logic yb);
    return (xp & yb) | (xp & ~xn) | (yb & ~xn);
  endfunction

  // Interim minus bit: set when the local sum is odd.
  function automatic logic ppm_interim(input logic xp, input logic xn, input logic yb);
    return xp ^ xn ^ yb;
  endfunction

endpackage

// File: rtl/sd_ppm_cell.sv
module sd_ppm_cell
  import sd_pkg::*;
(
  input  logic xp,
  input  logic xn,
  input  logic yb,
  output logic xfer,
  output logic interim_neg
);
  always_comb begin
    xfer        = ppm_xfer(xp, xn, yb);
    interim_neg = ppm_interim(xp, xn, yb);
  end
endmodule

// File: rtl/sd_out_stage.sv
module sd_out_stage #(
  parameter int WIDTH = 5,
  parameter bit REG   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_pos,
  input  logic [WIDTH-1:0] d_neg,
  output logic [WIDTH-1:0] q_pos,
  output logic [WIDTH-1:0] q_neg
);
  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_pos <= '0;
          q_neg <= '0;
        end else begin
          q_pos <= d_pos;
          q_neg <= d_neg;
        end
      end
    end else begin : g_comb
      always_comb begin
        q_pos = d_pos;
        q_neg = d_neg;
      end
    end
  endgenerate
endmodule

// File: rtl/sd_hybrid_adder.sv
module sd_hybrid_adder #(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] x_pos,
  input  logic [W-1:0] x_neg,
  input  logic [W-1:0] y,
  output logic [W:0]   s_pos,
  output logic [W:0]   s_neg
);
  localparam int SW = W + 1;

  // Per-position events, named for the checker.
  logic [W-1:0]  xfer_w;
  logic [W-1:0]  interim_w;
  logic [SW-1:0] sum_pos_w;
  logic [SW-1:0] sum_neg_w;

  generate
    for (genvar i = 0; i < W; i++) begin : g_cell
      sd_ppm_cell u_cell (
        .xp          (x_pos[i]),
        .xn          (x_neg[i]),
        .yb          (y[i]),
        .xfer        (xfer_w[i]),
        .interim_neg (interim_w[i])
      );
    end
  endgenerate

  // Second step: the transfer moves up one place, the interim bit stays put.
  always_comb begin
    sum_pos_w = {xfer_w, 1'b0};
    sum_neg_w = {1'b0, interim_w};
  end

  sd_out_stage #(.WIDTH(SW), .REG(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d_pos (sum_pos_w),
    .d_neg (sum_neg_w),
    .q_pos (s_pos),
    .q_neg (s_neg)
  );
endmodule

// File: rtl/sd_hybrid_adder_chk.sv
module sd_hybrid_adder_chk #(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] x_pos,
  input logic [W-1:0] x_neg,
  input logic [W-1:0] y,
  input logic [W:0]   s_pos,
  input logic [W:0]   s_neg,
  input logic [W-1:0] xfer,
  input logic [W-1:0] interim
);
  function automatic int sd_val(input logic [W:0] p, input logic [W:0] n);
    int acc = 0;
    for (int k = 0; k <= W; k++) acc += (int'(p[k]) - int'(n[k])) * (1 << k);
    return acc;
  endfunction

  function automatic int in_val(input logic [W-1:0] p, input logic [W-1:0] n,
                                input logic [W-1:0] b);
    int acc = 0;
    for (int k = 0; k < W; k++) acc += (int'(p[k]) - int'(n[k]) + int'(b[k])) * (1 << k);
    return acc;
  endfunction

  logic primed;
  always_ff @(posedge clk) primed <= rst_n;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pos
      // R3
      cell_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (2 * int'(xfer[i]) - int'(interim[i])) ==
        (int'(x_pos[i]) - int'(x_neg[i]) + int'(y[i])))
        else $error("cell relation broken at %0d", i);
    end

    if (REG_OUT) begin : g_reg
      // R2
      exact_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> sd_val(s_pos, s_neg) == $past(in_val(x_pos, x_neg, y)))
        else $error("sum value mismatch");
      for (genvar i = 1; i < W; i++) begin : g_route
        // R4
        digit_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
          primed |-> (s_pos[i] == $past(xfer[i-1]) && s_neg[i] == $past(interim[i])))
          else $error("digit routing wrong at %0d", i);
      end
      // R8
      reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (s_pos == '0 && s_neg == '0))
        else $error("reset did not clear result");
    end else begin : g_comb
      // R2
      exact_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_val(s_pos, s_neg) == in_val(x_pos, x_neg, y))
        else $error("sum value mismatch");
    end
  endgenerate

  // R5
  lsb_plus_chk: assert property (@(posedge clk) disable iff (!rst_n) !s_pos[0])
    else $error("lowest plus bit set");
  // R6
  top_minus_chk: assert property (@(posedge clk) disable iff (!rst_n) !s_neg[W])
    else $error("top minus bit set");
endmodule

bind sd_hybrid_adder sd_hybrid_adder_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .x_pos   (x_pos),
  .x_neg   (x_neg),
  .y       (y),
  .s_pos   (s_pos),
  .s_neg   (s_neg),
  .xfer    (xfer_w),
  .interim (interim_w)
);

// File: tb/test_sd_hybrid_adder.sv
module test_sd_hybrid_adder;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] x_pos = '0, x_neg = '0, y = '0;
  logic [W:0]   s_pos, s_neg;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sd_hybrid_adder #(.W(W), .REG_OUT(1'b1)) i_sd_hybrid_adder (
    .clk(clk), .rst_n(rst_n), .x_pos(x_pos), .x_neg(x_neg), .y(y),
    .s_pos(s_pos), .s_neg(s_neg)
  );

  typedef struct {
    logic [W:0] ep;
    logic [W:0] en;
    int         val;
    bit         zero11;
  } item_t;

  item_t sbq[$];

  // R1: digit value is plus minus minus, weighted by 2^i.
  function automatic int digits_value(input logic [W:0] p, input logic [W:0] n);
    int acc = 0;
    for (int k = 0; k <= W; k++) begin
      if (p[k] && !n[k]) acc += (1 << k);
      if (n[k] && !p[k]) acc -= (1 << k);
    end
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: applies one vector and pushes the expected digits.
  task automatic drive(input logic [W-1:0] xp, input logic [W-1:0] xn, input logic [W-1:0] yb);
    item_t it;
    @(negedge clk);
    x_pos = xp; x_neg = xn; y = yb;
    it.ep = '0; it.en = '0; it.val = 0; it.zero11 = |(xp & xn);
    for (int k = 0; k < W; k++) begin
      int p;
      p = (xp[k] ? 1 : 0) - (xn[k] ? 1 : 0) + (yb[k] ? 1 : 0);
      it.val += p * (1 << k);
      if (p >= 1) it.ep[k+1] = 1'b1;          // transfer moves up one place
      if (p == 1 || p == -1) it.en[k] = 1'b1; // odd local sum stays in place
    end
    sbq.push_back(it);
  endtask

  // Monitor: one cycle of latency (R7), sampled mid-period.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        if (it.zero11)
          check(digits_value(s_pos, s_neg) == it.val, "R9", digits_value(s_pos, s_neg), it.val);
        else
          check(digits_value(s_pos, s_neg) == it.val, "R2/R7", digits_value(s_pos, s_neg), it.val);
        check(s_pos[W-1:1] == it.ep[W-1:1], "R4", int'(s_pos), int'(it.ep));
        check(s_neg[W-1:0] == it.en[W-1:0], "R3", int'(s_neg), int'(it.en));
        check(s_pos[0] == 1'b0, "R5", int'(s_pos[0]), 0);
        check(s_neg[W] == 1'b0 && s_pos[W] == it.ep[W], "R6",
              int'({s_pos[W], s_neg[W]}), int'({it.ep[W], 1'b0}));
      end
    end
  end

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8: reset clears the result even with nonzero inputs.
    x_pos = '1; x_neg = '0; y = '1;
    repeat (3) @(posedge clk);
    #5;
    check(s_pos == '0 && s_neg == '0, "R8", int'({s_pos, s_neg}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Exhaustive: every digit code (00,01,10,11) at every position, every Y.
    for (int xc = 0; xc < (1 << (2 * W)); xc++) begin
      for (int yv = 0; yv < (1 << W); yv++) begin
        logic [W-1:0] xp, xn;
        for (int k = 0; k < W; k++) begin
          xp[k] = xc[2*k];
          xn[k] = xc[2*k+1];
        end
        drive(xp, xn, yv[W-1:0]);
      end
    end
    @(negedge clk);
    @(negedge clk);

    // R10: a change at position j touches only digits j and j+1.
    for (int j = 0; j < W; j++) begin
      logic [W:0] bp, bn, diff;
      @(negedge clk);
      x_pos = '0; x_neg = '0; y = '0;
      @(posedge clk); #5;
      bp = s_pos; bn = s_neg;
      @(negedge clk);
      x_pos = '0; x_neg = '0; y = '0;
      x_pos[j] = 1'b1; y[j] = 1'b1;
      @(posedge clk); #5;
      diff = (s_pos ^ bp) | (s_neg ^ bn);
      check((diff & ~((W+1)'(3) << j)) == '0 && diff != '0, "R10", int'(diff), int'((W+1)'(3) << j));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule